// File: doc/BRIEF.md
# Three-Wire Serial to Byte-Wide RAM Bridge

This block is a slave on a three-wire serial bus made of an enable line, a serial clock and a data line. While the enable line is high, the host shifts in a 56-bit command frame. The frame carries an access class, a start address for a 19-bit byte-wide RAM and a 5-bit command code. The bridge then streams RAM bytes out onto the data line, or takes bytes from the data line and writes them to RAM. Each byte goes least significant bit first, and the address steps by one after every byte. The data line is split into an input, an output and an output enable, so the pad logic around the block can build the bidirectional pin.

All three serial lines are synchronised into the system clock domain and edge-detected there. The host sets the pace of the whole transfer. No flow control is needed, and there is no back-pressure at either edge. The RAM port is a plain synchronous port: it must accept a strobe in any cycle and return read data one cycle after the read strobe. Each high or low phase of the serial clock must last at least eight system clock cycles.

Taking the enable line low ends any transfer at once. A write byte whose last bit has just arrived is still written to RAM. An unfinished byte is dropped.

Top module: `ser_ram_bridge`

## Requirements
- R1: Frame bits are sampled on rising serial clock edges. Bit i of the frame is the i-th bit received, and each byte arrives LSB first. The access class is frame[7:0], read with frame[7] as the most significant bit. Address bit k is frame[8+k], for k from 0 to 18. The command code is frame[31:27], with frame[31] as the leftmost digit.
- R2: The access class 8'hE8 is the read class and 8'h17 is the write class. With any other class value, the frame causes no RAM strobe and the data line is never driven.
- R3: Burst read (code 00110, or any code 11xxx, both in the read class) fetches the byte at the start address. The byte's bits go onto ser_dq_out LSB first. Each bit changes after a falling serial clock edge and holds through the following rising edge, and ser_dq_oe is high while bits are being sent.
- R4: Burst write (code 10001 in the write class) assembles eight data bits, LSB first, and issues exactly one single-cycle ram_we with that byte.
- R5: After every burst byte the address increases by one, and it wraps from 7FFFF to 00000.
- R6: When the enable line goes low before a write byte's eighth bit has arrived, that partial byte is never written.
- R7: When the enable line falls in the same cycle as the eighth rising edge of a write byte, that byte is still written.
- R8: Write-select (code 01110, write class) stores the first data byte in an internal select register and ignores later bits. Read-select (code 00101, read class) returns that register on every data byte, with no RAM strobe.
- R9: A code that does not match its class, and the codes 00011, 10110 and 01001, cause no RAM strobe and leave the data line undriven.
- R10: While the enable line is low, the frame bit count is zero and ser_dq_oe is low. A frame that was cut short has no effect on the next frame.
- R11: After reset, ram_we, ram_re and ser_dq_oe are low.
- R12: Read data is taken from ram_rdata exactly one cycle after ram_re, and ram_we and ram_re are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_en | input | 1 | Serial transfer enable; low aborts the transfer |
| ser_clk | input | 1 | Serial bit clock from the host |
| ser_dq_in | input | 1 | Serial data from the host |
| ser_dq_out | output | 1 | Serial data to the host |
| ser_dq_oe | output | 1 | High while the bridge drives the data line |
| ram_addr | output | 19 | RAM byte address |
| ram_wdata | output | 8 | RAM write data |
| ram_we | output | 1 | RAM write strobe, one cycle per byte |
| ram_re | output | 1 | RAM read strobe, data expected one cycle later |
| ram_rdata | input | 8 | RAM read data |

## Verification
Two events can land in the same system cycle: the commit of a completed write byte and the abort caused by the enable line falling. The bench provokes this by raising the serial clock for the eighth bit and dropping the enable line in the same time step, so both pass through the synchroniser together. The RAM write log is the judge. It must show exactly one write, at the right address and with the full byte. A companion case drops the enable line after half a byte and must show no write for that byte.

// File: rtl/ser_bridge_pkg.sv
package ser_bridge_pkg;
  localparam int CMD_W = 5;

  localparam logic [7:0] CLASS_READ  = 8'hE8;
  localparam logic [7:0] CLASS_WRITE = 8'h17;

  localparam logic [CMD_W-1:0] CODE_BURST_RD = 5'b00110;
  localparam logic [CMD_W-1:0] CODE_BURST_WR = 5'b10001;
  localparam logic [CMD_W-1:0] CODE_SEL_RD   = 5'b00101;
  localparam logic [CMD_W-1:0] CODE_SEL_WR   = 5'b01110;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_RAM_RD,
    OP_RAM_WR,
    OP_SEL_RD,
    OP_SEL_WR
  } bridge_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_SEND,
    ST_RECV,
    ST_HOLD
  } burst_state_e;
endpackage

// File: rtl/sb_line_sync.sv
module sb_line_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q,
  output logic [WIDTH-1:0] rise,
  output logic [WIDTH-1:0] fall
);
  logic [WIDTH-1:0] pipe [STAGES];
  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
      prev_q <= '0;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
      prev_q <= pipe[STAGES-1];
    end
  end

  assign q    = pipe[STAGES-1];
  assign rise = q & ~prev_q;
  assign fall = ~q & prev_q;
endmodule

// File: rtl/sb_frame_rx.sv
module sb_frame_rx
  import ser_bridge_pkg::*;
#(
  parameter int FRAME_BITS = 56,
  parameter int ADDR_W     = 19
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              rise,
  input  logic              din,
  output logic              frame_done,
  output bridge_op_e        op,
  output logic [ADDR_W-1:0] start_addr
);
  localparam int CW       = $clog2(FRAME_BITS + 1);
  localparam int ADDR_LSB = 8;
  localparam int CMD_LSB  = ADDR_LSB + ADDR_W;

  logic [FRAME_BITS-1:0] frame_q;
  logic [CW-1:0]         cnt_q;
  logic                  done_q;
  logic [7:0]            cls;
  logic [CMD_W-1:0]      code;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q <= '0;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!en) begin
        cnt_q <= '0;
      end else if (rise && cnt_q != CW'(FRAME_BITS)) begin
        frame_q[cnt_q] <= din;
        cnt_q          <= cnt_q + 1'b1;
        if (cnt_q == CW'(FRAME_BITS - 1)) done_q <= 1'b1;
      end
    end
  end

  always_comb begin
    cls  = frame_q[7:0];
    code = frame_q[CMD_LSB +: CMD_W];
    op   = OP_NONE;
    if (cls == CLASS_READ) begin
      if (code == CODE_BURST_RD || code[CMD_W-1 -: 2] == 2'b11) op = OP_RAM_RD;
      else if (code == CODE_SEL_RD)                             op = OP_SEL_RD;
    end else if (cls == CLASS_WRITE) begin
      if (code == CODE_BURST_WR)    op = OP_RAM_WR;
      else if (code == CODE_SEL_WR) op = OP_SEL_WR;
    end
  end

  assign start_addr = frame_q[ADDR_LSB +: ADDR_W];
  assign frame_done = done_q;

  // R1: the end of a frame is signalled exactly once
  p_done_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);

  // R10: the bit count cannot advance while the enable line is low
  p_cnt_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && $past(!en)) |-> cnt_q == '0);
endmodule

// File: rtl/sb_burst_engine.sv
module sb_burst_engine
  import ser_bridge_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              rise,
  input  logic              fall,
  input  logic              din,
  input  logic              frame_done,
  input  bridge_op_e        op,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [DATA_W-1:0] ram_rdata,
  output logic              dq_out,
  output logic              dq_oe,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [DATA_W-1:0] ram_wdata,
  output logic              ram_we,
  output logic              ram_re
);
  localparam int BC_W = $clog2(DATA_W);
  localparam logic [BC_W-1:0] LAST_BIT = BC_W'(DATA_W - 1);

  burst_state_e      state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] shreg_q, sel_q, wdata_q, asm_byte;
  logic [BC_W-1:0]   bitcnt_q;
  logic              is_sel_q, wait_q, we_q, re_q, dq_q, oe_q, commit;

  always_comb begin
    asm_byte = {din, shreg_q[DATA_W-1:1]};
    commit   = (state_q == ST_RECV) && rise && (bitcnt_q == LAST_BIT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      addr_q   <= '0;
      shreg_q  <= '0;
      sel_q    <= '0;
      wdata_q  <= '0;
      bitcnt_q <= '0;
      is_sel_q <= 1'b0;
      wait_q   <= 1'b0;
      we_q     <= 1'b0;
      re_q     <= 1'b0;
      dq_q     <= 1'b0;
      oe_q     <= 1'b0;
    end else begin
      we_q <= 1'b0;
      re_q <= 1'b0;
      if (we_q) addr_q <= addr_q + 1'b1;
      if (commit) begin
        if (is_sel_q) sel_q <= asm_byte;
        else begin
          we_q    <= 1'b1;
          wdata_q <= asm_byte;
        end
      end
      if (!en) begin
        state_q  <= ST_IDLE;
        oe_q     <= 1'b0;
        bitcnt_q <= '0;
        wait_q   <= 1'b0;
      end else begin
        unique case (state_q)
          ST_IDLE: if (frame_done) begin
            addr_q   <= start_addr;
            bitcnt_q <= '0;
            case (op)
              OP_RAM_RD: begin is_sel_q <= 1'b0; re_q <= 1'b1; wait_q <= 1'b1; state_q <= ST_FETCH; end
              OP_SEL_RD: begin is_sel_q <= 1'b1; wait_q <= 1'b1; state_q <= ST_FETCH; end
              OP_RAM_WR: begin is_sel_q <= 1'b0; state_q <= ST_RECV; end
              OP_SEL_WR: begin is_sel_q <= 1'b1; state_q <= ST_RECV; end
              default:   state_q <= ST_HOLD;
            endcase
          end
          ST_FETCH: if (wait_q) begin
            wait_q <= 1'b0;
          end else begin
            shreg_q <= is_sel_q ? sel_q : ram_rdata;
            if (!is_sel_q) addr_q <= addr_q + 1'b1;
            state_q <= ST_SEND;
          end
          ST_SEND: if (fall) begin
            dq_q     <= shreg_q[0];
            oe_q     <= 1'b1;
            shreg_q  <= shreg_q >> 1;
            bitcnt_q <= bitcnt_q + 1'b1;
            if (bitcnt_q == LAST_BIT) begin
              state_q <= ST_FETCH;
              wait_q  <= 1'b1;
              re_q    <= !is_sel_q;
            end
          end
          ST_RECV: if (rise) begin
            shreg_q  <= asm_byte;
            bitcnt_q <= bitcnt_q + 1'b1;
            if (bitcnt_q == LAST_BIT && is_sel_q) state_q <= ST_HOLD;
          end
          ST_HOLD: ;
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign ram_addr  = addr_q;
  assign ram_wdata = wdata_q;
  assign ram_we    = we_q;
  assign ram_re    = re_q;
  assign dq_out    = dq_q;
  assign dq_oe     = oe_q;

  // R12: read and write strobes never overlap
  p_strobe_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(ram_we && ram_re));

  // R4: one write strobe per byte, never two in a row
  p_we_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |=> !ram_we);

  // R5: the address steps by one right after each written byte
  p_addr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |=> ram_addr == ADDR_W'($past(ram_addr) + 1'b1));

  // R10: output enable drops once the enable line is low
  p_oe_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !dq_oe);

  // R3: driven data only changes after a falling serial edge
  p_dq_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_oe && $past(dq_oe) && !$past(fall)) |-> $stable(dq_out));
endmodule

// File: rtl/ser_ram_bridge.sv
module ser_ram_bridge
  import ser_bridge_pkg::*;
#(
  parameter int ADDR_W      = 19,
  parameter int DATA_W      = 8,
  parameter int FRAME_BITS  = 56,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_en,
  input  logic              ser_clk,
  input  logic              ser_dq_in,
  output logic              ser_dq_out,
  output logic              ser_dq_oe,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [DATA_W-1:0] ram_wdata,
  output logic              ram_we,
  output logic              ram_re,
  input  logic [DATA_W-1:0] ram_rdata
);
  localparam int LINES = 3;
  localparam int L_EN  = 0;
  localparam int L_CLK = 1;
  localparam int L_DQ  = 2;

  logic [LINES-1:0]  lvl, rise_v, fall_v;
  logic              frame_done;
  bridge_op_e        op;
  logic [ADDR_W-1:0] start_addr;

  sb_line_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({ser_dq_in, ser_clk, ser_en}),
    .q    (lvl),
    .rise (rise_v),
    .fall (fall_v)
  );

  sb_frame_rx #(.FRAME_BITS(FRAME_BITS), .ADDR_W(ADDR_W)) u_frame (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (lvl[L_EN]),
    .rise      (rise_v[L_CLK]),
    .din       (lvl[L_DQ]),
    .frame_done(frame_done),
    .op        (op),
    .start_addr(start_addr)
  );

  sb_burst_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_engine (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (lvl[L_EN]),
    .rise      (rise_v[L_CLK]),
    .fall      (fall_v[L_CLK]),
    .din       (lvl[L_DQ]),
    .frame_done(frame_done),
    .op        (op),
    .start_addr(start_addr),
    .ram_rdata (ram_rdata),
    .dq_out    (ser_dq_out),
    .dq_oe     (ser_dq_oe),
    .ram_addr  (ram_addr),
    .ram_wdata (ram_wdata),
    .ram_we    (ram_we),
    .ram_re    (ram_re)
  );
endmodule

// File: tb/ser_ram_bridge_test.sv
module ser_ram_bridge_test;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 100;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ser_en = 1'b0, ser_clk = 1'b0, ser_dq_in = 1'b0;
  logic        ser_dq_out, ser_dq_oe;
  logic [18:0] ram_addr;
  logic [7:0]  ram_wdata, ram_rdata;
  logic        ram_we, ram_re;

  int checks = 0;
  int failures = 0;

  logic [7:0]  mem [logic [18:0]];
  logic [18:0] wr_addr [32];
  logic [7:0]  wr_data [32];
  int          wr_cnt = 0;
  int          re_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ser_ram_bridge uut (
    .clk(clk), .rst_n(rst_n), .ser_en(ser_en), .ser_clk(ser_clk),
    .ser_dq_in(ser_dq_in), .ser_dq_out(ser_dq_out), .ser_dq_oe(ser_dq_oe),
    .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_we(ram_we),
    .ram_re(ram_re), .ram_rdata(ram_rdata)
  );

  always @(posedge clk) begin
    if (ram_we) begin
      mem[ram_addr] = ram_wdata;
      wr_addr[wr_cnt % 32] = ram_addr;
      wr_data[wr_cnt % 32] = ram_wdata;
      wr_cnt++;
    end
    if (ram_re) begin
      ram_rdata <= mem.exists(ram_addr) ? mem[ram_addr] : 8'h00;
      re_cnt++;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [55:0] mk_frame(input logic [7:0] cls, input logic [4:0] code,
                                           input logic [18:0] addr);
    logic [55:0] f = '0;
    f[7:0]   = cls;
    f[26:8]  = addr;
    f[31:27] = code;
    return f;
  endfunction

  task automatic ser_bit(input logic b);
    ser_dq_in = b;
    #HALF ser_clk = 1'b1;
    #HALF ser_clk = 1'b0;
  endtask

  task automatic ser_byte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) ser_bit(v[i]);
  endtask

  task automatic ser_frame(input logic [55:0] f);
    ser_en = 1'b1;
    #HALF;
    for (int i = 0; i < 56; i++) ser_bit(f[i]);
  endtask

  task automatic ser_get(output logic [7:0] v, inout logic oe_seen);
    for (int i = 0; i < 8; i++) begin
      #HALF;
      v[i] = ser_dq_out;
      oe_seen = oe_seen | ser_dq_oe;
      ser_clk = 1'b1;
      #HALF ser_clk = 1'b0;
    end
  endtask

  task automatic ser_end();
    ser_en = 1'b0;
    #(HALF*2);
  endtask

  task automatic t_reset();
    check("R11 ram_we after reset", ram_we, 0);
    check("R11 ram_re after reset", ram_re, 0);
    check("R11 dq_oe after reset", ser_dq_oe, 0);
  endtask

  task automatic t_burst_write();
    int base = wr_cnt;
    ser_frame(mk_frame(8'h17, 5'b10001, 19'h12345));
    ser_byte(8'hA5); ser_byte(8'h3C); ser_byte(8'hF0);
    ser_end();
    check("R4 write count", wr_cnt - base, 3);
    check("R1 R4 first addr", wr_addr[base % 32], 19'h12345);
    check("R4 first data", wr_data[base % 32], 8'hA5);
    check("R5 second addr", wr_addr[(base+1) % 32], 19'h12346);
    check("R4 second data", wr_data[(base+1) % 32], 8'h3C);
    check("R5 third addr", wr_addr[(base+2) % 32], 19'h12347);
    check("R4 third data", wr_data[(base+2) % 32], 8'hF0);
  endtask

  task automatic t_burst_read();
    logic [7:0] v;
    logic oe = 1'b0;
    int rb = re_cnt;
    ser_frame(mk_frame(8'hE8, 5'b00110, 19'h12345));
    ser_get(v, oe); check("R3 R12 read byte0", v, 8'hA5);
    ser_get(v, oe); check("R3 R5 read byte1", v, 8'h3C);
    ser_get(v, oe); check("R3 R5 read byte2", v, 8'hF0);
    check("R3 dq_oe during read", oe, 1);
    ser_end();
    check("R10 dq_oe released", ser_dq_oe, 0);
    check("R12 read strobes issued", (re_cnt - rb) >= 3, 1);
  endtask

  task automatic t_wrap();
    logic [7:0] v;
    logic oe = 1'b0;
    int base = wr_cnt;
    ser_frame(mk_frame(8'h17, 5'b10001, 19'h7FFFF));
    ser_byte(8'h11); ser_byte(8'h22);
    ser_end();
    check("R5 wrap addr top", wr_addr[base % 32], 19'h7FFFF);
    check("R5 wrap addr zero", wr_addr[(base+1) % 32], 19'h00000);
    ser_frame(mk_frame(8'hE8, 5'b11010, 19'h7FFFF));
    ser_get(v, oe); check("R3 masked read byte0", v, 8'h11);
    ser_get(v, oe); check("R3 R5 masked read wraps", v, 8'h22);
    ser_end();
  endtask

  task automatic t_partial();
    int base = wr_cnt;
    ser_frame(mk_frame(8'h17, 5'b10001, 19'h00100));
    ser_byte(8'h81);
    for (int i = 0; i < 4; i++) ser_bit(1'b1);
    ser_end();
    check("R6 only full byte written", wr_cnt - base, 1);
    check("R6 full byte data", wr_data[base % 32], 8'h81);
  endtask

  task automatic t_collision();
    logic [7:0] v = 8'hC3;
    int base = wr_cnt;
    ser_frame(mk_frame(8'h17, 5'b10001, 19'h00200));
    for (int i = 0; i < 7; i++) ser_bit(v[i]);
    ser_dq_in = v[7];
    #HALF;
    ser_clk = 1'b1;
    ser_en  = 1'b0;
    #HALF ser_clk = 1'b0;
    #(HALF*2);
    check("R7 byte kept on abort", wr_cnt - base, 1);
    check("R7 addr", wr_addr[base % 32], 19'h00200);
    check("R7 data", wr_data[base % 32], 8'hC3);
  endtask

  task automatic t_bad_frames();
    logic [7:0] v;
    logic oe = 1'b0;
    int wb = wr_cnt;
    int rb = re_cnt;
    ser_frame(mk_frame(8'hFF, 5'b10001, 19'h00400));
    ser_byte(8'h55);
    ser_end();
    check("R2 bad class no write", wr_cnt - wb, 0);
    ser_frame(mk_frame(8'hE8, 5'b10001, 19'h00400));
    ser_get(v, oe);
    ser_end();
    check("R9 class mismatch no read", re_cnt - rb, 0);
    check("R9 class mismatch no drive", oe, 0);
    ser_frame(mk_frame(8'hE8, 5'b00011, 19'h00400));
    ser_get(v, oe);
    ser_end();
    ser_frame(mk_frame(8'h17, 5'b10110, 19'h00400));
    ser_byte(8'h66);
    ser_end();
    check("R9 unsupported no write", wr_cnt - wb, 0);
    check("R9 unsupported no read", re_cnt - rb, 0);
    check("R9 unsupported no drive", oe, 0);
  endtask

  task automatic t_select();
    logic [7:0] v;
    logic oe = 1'b0;
    int wb = wr_cnt;
    int rb = re_cnt;
    ser_frame(mk_frame(8'h17, 5'b01110, 19'h0));
    ser_byte(8'h5A); ser_byte(8'hFF);
    ser_end();
    ser_frame(mk_frame(8'hE8, 5'b00101, 19'h0));
    ser_get(v, oe); check("R8 select byte0", v, 8'h5A);
    ser_get(v, oe); check("R8 select repeats", v, 8'h5A);
    ser_end();
    check("R8 no RAM write", wr_cnt - wb, 0);
    check("R8 no RAM read", re_cnt - rb, 0);
  endtask

  task automatic t_cut_frame();
    logic [55:0] junk = mk_frame(8'h17, 5'b10001, 19'h07777);
    logic [7:0] v;
    int base = wr_cnt;
    ser_en = 1'b1;
    #HALF;
    for (int i = 0; i < 20; i++) ser_bit(junk[i]);
    ser_end();
    ser_frame(mk_frame(8'h17, 5'b10001, 19'h00300));
    ser_byte(8'h99);
    ser_end();
    check("R10 fresh frame write count", wr_cnt - base, 1);
    check("R10 fresh frame addr", wr_addr[base % 32], 19'h00300);
    ser_frame(mk_frame(8'hE8, 5'b00110, 19'h00300));
    for (int i = 0; i < 3; i++) begin
      #HALF v[i] = ser_dq_out;
      ser_clk = 1'b1;
      #HALF ser_clk = 1'b0;
    end
    ser_en = 1'b0;
    #(CLK_PERIOD*10);
    check("R10 dq_oe drops on abort", ser_dq_oe, 0);
    #(HALF*2);
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD*3 + 3);
    rst_n = 1'b1;
    #(HALF*2);
    t_reset();
    t_burst_write();
    t_burst_read();
    t_wrap();
    t_partial();
    t_collision();
    t_bad_frames();
    t_select();
    t_cut_frame();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule